// File: doc/BRIEF.md
# Paired-Write Shadow Register Bank

This block holds a small set of configuration registers that are loaded through 6-bit address slots. A front end that has already decoded the serial stream supplies the slot address, six data bits and a write strobe. A register wider than six bits uses two neighbouring slots. The lower slot carries the six least significant bits and the next slot up carries the rest. The register is assembled from a write to the lower slot followed by a write to the upper slot. A register that fits in one slot is staged by a single write.

A staged value does not reach the outputs at once. It waits in a shadow stage until the commit event of its update class. Load-class registers commit on a rising edge of the serial load input. Sync-class registers commit on the leading edge of a horizontal sync pulse. That pulse must fall on the field line chosen by a 12-bit line-select register, and it is blocked while the hold register is set. A polarity register decides whether vertical and horizontal sync are active low or active high. Horizontal pulses are counted from the most recent vertical leading edge.

Slot map (hex): mode 00/01 (8 bits, load), gain 02/03 (10 bits, sync), clamp 04/05 (8 bits, sync), tint 08 (6 bits, sync), line-select 10/11 (12 bits, load), hold 12 (bit 0, load), sync polarity 13 (bit 0, load), field flag 14 (bit 0, sync).

Top module: `shadow_bank`

## Requirements
- R1: After reset the outputs read mode 0x00, gain 0x096, clamp 0x080, tint 0x00, line-select 0x000, hold 0, polarity 0 and field flag 1.
- R2: A write to a wide register's lower slot followed by a write to its upper slot stages {upper data, lower data}. At the register's next commit event this value appears on the output.
- R3: A write to a wide register's lower slot with no upper write after it leaves that register's output unchanged, whatever commit events follow.
- R4: A write to a wide register's upper slot with no lower write before it still stages a full value. Its six low bits are the last data written to the lower slot, or the low bits of the reset value if the lower slot was never written.
- R5: Load-class outputs (mode, line-select, hold, polarity) change only at a clock edge where sload is sampled high after being sampled low on the edge before.
- R6: Sync-class outputs (gain, clamp, tint, field flag) change only at a clock edge that sees a horizontal leading edge. Serial load has no effect on them.
- R7: A sync commit happens on a horizontal leading edge when the number of horizontal leading edges seen since the last vertical leading edge equals line-select. Line-select N therefore commits on the (N+1)-th horizontal pulse of the field.
- R8: While hold is 1, no sync-class output changes. A value staged during hold commits at the first qualifying horizontal edge after hold returns to 0.
- R9: With polarity 0 the sync inputs are active low and the leading edge is a falling edge. With polarity 1 they are active high and the leading edge is a rising edge.
- R10: Writes to slots outside the map change no output.
- R11: A single-slot register (tint, hold, polarity, field flag) is staged by one write to its slot and commits at its class event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Slot write strobe |
| wr_addr | input | 6 | Slot address |
| wr_data | input | 6 | Slot data |
| sload | input | 1 | Serial load; a rising edge commits load-class values |
| vd | input | 1 | Vertical sync, polarity set by sync_pol_q |
| hd | input | 1 | Horizontal sync, polarity set by sync_pol_q |
| mode_q | output | 8 | Active mode register |
| gain_q | output | 10 | Active gain register |
| clamp_q | output | 8 | Active clamp level |
| tint_q | output | 6 | Active tint register |
| line_sel_q | output | 12 | Active line-select value |
| hold_q | output | 1 | Active hold flag |
| sync_pol_q | output | 1 | Active sync polarity |
| field_q | output | 1 | Active field flag |

## Verification
A slot write is taken at the rising edge that samples wr_en. A commit appears on the outputs at the very rising edge that samples the sload rise or the horizontal leading edge, with no extra register in between. The bench drives every input on falling edges and reads the outputs at the falling edge that follows the committing rising edge. Before each event it also reads the outputs at one falling edge, to show that no value moved early. In the line-select test, the output is read after each horizontal pulse. This shows the value arrives on the selected pulse and not on the one before it.

// File: rtl/shadow_bank_pkg.sv
// Package: shared widths, slot addresses and update classes for the
// shadow register bank. Assumes 6-bit slots and a 6-bit slot address.
package shadow_bank_pkg;
    localparam int SLOT_W  = 6;
    localparam int ADDR_W  = 6;
    localparam int LINE_W  = 2 * SLOT_W;
    localparam int MODE_W  = 8;
    localparam int GAIN_W  = 10;
    localparam int CLAMP_W = 8;
    localparam int TINT_W  = 6;

    typedef enum logic { UPD_LOAD = 1'b0, UPD_SYNC = 1'b1 } upd_cls_t;

    localparam logic [ADDR_W-1:0] A_MODE  = 6'h00;
    localparam logic [ADDR_W-1:0] A_GAIN  = 6'h02;
    localparam logic [ADDR_W-1:0] A_CLAMP = 6'h04;
    localparam logic [ADDR_W-1:0] A_TINT  = 6'h08;
    localparam logic [ADDR_W-1:0] A_LINE  = 6'h10;
    localparam logic [ADDR_W-1:0] A_HOLD  = 6'h12;
    localparam logic [ADDR_W-1:0] A_POL   = 6'h13;
    localparam logic [ADDR_W-1:0] A_FIELD = 6'h14;
endpackage

// File: rtl/sb_cell.sv
// Module: one configuration register with a shadow stage.
// Registers wider than one slot take their low bits from a low staging
// latch and stage on the upper-slot write. Narrower registers stage on
// their single slot. The staged value moves to q on the commit event of
// the register's class. Assumes 1 <= W <= 2*SLOT_W.
module sb_cell
    import shadow_bank_pkg::*;
#(
    parameter int               W       = 6,
    parameter logic [ADDR_W-1:0] LO_ADDR = '0,
    parameter logic [W-1:0]     RST_VAL = '0,
    parameter upd_cls_t         CLS     = UPD_LOAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic              load_evt,
    input  logic              sync_evt,
    output logic [W-1:0]      q
);
    localparam bit WIDE = (W > SLOT_W);

    logic [W-1:0] shadow_q;
    logic         armed_q;
    logic [W-1:0] stage_nxt;
    logic         stage_we;
    logic         commit;
    logic         unused_data;

    assign unused_data = ^wr_data;
    assign commit      = (CLS == UPD_SYNC) ? sync_evt : load_evt;

    generate
        if (WIDE) begin : g_wide
            localparam int               HI_W    = W - SLOT_W;
            localparam logic [ADDR_W-1:0] HI_ADDR = LO_ADDR + ADDR_W'(1);
            logic [SLOT_W-1:0] lo_q;
            logic              hit_lo;

            assign hit_lo = wr_en && (wr_addr == LO_ADDR);

            // Low staging latch: keeps the last data written to the lower slot.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lo_q <= RST_VAL[SLOT_W-1:0];
                else if (hit_lo)
                    lo_q <= wr_data;
            end

            assign stage_we  = wr_en && (wr_addr == HI_ADDR);
            assign stage_nxt = {wr_data[HI_W-1:0], lo_q};
        end else begin : g_narrow
            assign stage_we  = wr_en && (wr_addr == LO_ADDR);
            assign stage_nxt = wr_data[W-1:0];
        end
    endgenerate

    // Shadow and active stages: a commit moves an armed shadow value to q; a
    // new staging write loads the shadow and wins the armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= RST_VAL;
            armed_q  <= 1'b0;
            q        <= RST_VAL;
        end else begin
            if (commit && armed_q) begin
                q       <= shadow_q;
                armed_q <= 1'b0;
            end
            if (stage_we) begin
                shadow_q <= stage_nxt;
                armed_q  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_sync.sv
// Module: commit event generator. Finds the sload rise and the leading
// edges of vd and hd after the polarity flip, counts hd leading edges
// from the last vd leading edge, and raises sync_evt on the selected line
// unless hold is set. Assumes the inputs are synchronous to clk.
module sb_sync #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sload,
    input  logic              vd,
    input  logic              hd,
    input  logic              pol,
    input  logic              hold,
    input  logic [LINE_W-1:0] line_sel,
    output logic              load_evt,
    output logic              sync_evt
);
    logic              sload_q, vd_q, hd_q;
    logic              vd_act, hd_act, vd_lead, hd_lead;
    logic [LINE_W-1:0] line_cnt;

    assign vd_act = pol ? vd : ~vd;
    assign hd_act = pol ? hd : ~hd;

    // Previous-cycle samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sload_q <= 1'b0;
            vd_q    <= 1'b0;
            hd_q    <= 1'b0;
        end else begin
            sload_q <= sload;
            vd_q    <= vd_act;
            hd_q    <= hd_act;
        end
    end

    assign vd_lead  = vd_act & ~vd_q;
    assign hd_lead  = hd_act & ~hd_q;
    assign load_evt = sload & ~sload_q;

    // Line counter: cleared by a vertical leading edge, advanced by horizontal ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_cnt <= '0;
        else if (vd_lead)
            line_cnt <= '0;
        else if (hd_lead)
            line_cnt <= line_cnt + 1'b1;
    end

    assign sync_evt = hd_lead && (line_cnt == line_sel) && !hold;
endmodule

// File: rtl/shadow_bank.sv
// Module: top of the paired-write shadow register bank. Routes the slot
// write port to every register cell and feeds each cell the commit event
// of its class. Assumes writes arrive already decoded, one per cycle.
module shadow_bank
    import shadow_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [SLOT_W-1:0]  wr_data,
    input  logic               sload,
    input  logic               vd,
    input  logic               hd,
    output logic [MODE_W-1:0]  mode_q,
    output logic [GAIN_W-1:0]  gain_q,
    output logic [CLAMP_W-1:0] clamp_q,
    output logic [TINT_W-1:0]  tint_q,
    output logic [LINE_W-1:0]  line_sel_q,
    output logic               hold_q,
    output logic               sync_pol_q,
    output logic               field_q
);
    localparam logic [GAIN_W-1:0]  GAIN_RST  = GAIN_W'(10'h096);
    localparam logic [CLAMP_W-1:0] CLAMP_RST = CLAMP_W'(8'h80);

    logic load_evt;
    logic sync_evt;

    sb_sync #(.LINE_W(LINE_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .sload(sload), .vd(vd), .hd(hd),
        .pol(sync_pol_q), .hold(hold_q), .line_sel(line_sel_q),
        .load_evt(load_evt), .sync_evt(sync_evt)
    );

    sb_cell #(.W(MODE_W), .LO_ADDR(A_MODE), .RST_VAL('0), .CLS(UPD_LOAD)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_evt(load_evt), .sync_evt(sync_evt), .q(mode_q)
    );

    sb_cell #(.W(GAIN_W), .LO_ADDR(A_GAIN), .RST_VAL(GAIN_RST), .CLS(UPD_SYNC)) u_gain (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_evt(load_evt), .sync_evt(sync_evt), .q(gain_q)
    );

    sb_cell #(.W(CLAMP_W), .LO_ADDR(A_CLAMP), .RST_VAL(CLAMP_RST), .CLS(UPD_SYNC)) u_clamp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_evt(load_evt), .sync_evt(sync_evt), .q(clamp_q)
    );

    sb_cell #(.W(TINT_W), .LO_ADDR(A_TINT), .RST_VAL('0), .CLS(UPD_SYNC)) u_tint (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_evt(load_evt), .sync_evt(sync_evt), .q(tint_q)
    );

    sb_cell #(.W(LINE_W), .LO_ADDR(A_LINE), .RST_VAL('0), .CLS(UPD_LOAD)) u_line (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_evt(load_evt), .sync_evt(sync_evt), .q(line_sel_q)
    );

    sb_cell #(.W(1), .LO_ADDR(A_HOLD), .RST_VAL(1'b0), .CLS(UPD_LOAD)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_evt(load_evt), .sync_evt(sync_evt), .q(hold_q)
    );

    sb_cell #(.W(1), .LO_ADDR(A_POL), .RST_VAL(1'b0), .CLS(UPD_LOAD)) u_pol (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_evt(load_evt), .sync_evt(sync_evt), .q(sync_pol_q)
    );

    sb_cell #(.W(1), .LO_ADDR(A_FIELD), .RST_VAL(1'b1), .CLS(UPD_SYNC)) u_field (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_evt(load_evt), .sync_evt(sync_evt), .q(field_q)
    );
endmodule

// File: rtl/shadow_bank_chk.sv
// Checker: temporal properties of the shadow bank, bound to the top.
// Assumes rst_n is low at the first clock edge.
module shadow_bank_chk
    import shadow_bank_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               hd,
    input logic               load_evt,
    input logic               sync_evt,
    input logic [MODE_W-1:0]  mode_q,
    input logic [GAIN_W-1:0]  gain_q,
    input logic [CLAMP_W-1:0] clamp_q,
    input logic [TINT_W-1:0]  tint_q,
    input logic [LINE_W-1:0]  line_sel_q,
    input logic               hold_q,
    input logic               sync_pol_q,
    input logic               field_q
);
    p_reset_values_r1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0 && gain_q == 10'h096 && clamp_q == 8'h80 &&
                    tint_q == '0 && line_sel_q == '0 && !hold_q && !sync_pol_q && field_q));

    p_load_class_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_evt |=> $stable({mode_q, line_sel_q, hold_q, sync_pol_q}));

    p_sync_class_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_evt |=> $stable({gain_q, clamp_q, tint_q, field_q}));

    p_sync_on_active_hd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |-> (sync_pol_q ? hd : !hd));

    p_hold_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> $stable({gain_q, clamp_q, tint_q, field_q}));
endmodule

bind shadow_bank shadow_bank_chk i_chk (
    .clk(clk), .rst_n(rst_n), .hd(hd), .load_evt(load_evt), .sync_evt(sync_evt),
    .mode_q(mode_q), .gain_q(gain_q), .clamp_q(clamp_q), .tint_q(tint_q),
    .line_sel_q(line_sel_q), .hold_q(hold_q), .sync_pol_q(sync_pol_q), .field_q(field_q)
);

// File: tb/test_shadow_bank.sv
// Directed bench for shadow_bank: one task per scenario, each checking itself.
module test_shadow_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [5:0]  wr_data = '0;
    logic        sload = 1'b0;
    logic        vd = 1'b1;
    logic        hd = 1'b1;
    logic [7:0]  mode_q;
    logic [9:0]  gain_q;
    logic [7:0]  clamp_q;
    logic [5:0]  tint_q;
    logic [11:0] line_sel_q;
    logic        hold_q, sync_pol_q, field_q;

    int checks = 0;
    int fails  = 0;
    bit pol    = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    shadow_bank i_shadow_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sload(sload), .vd(vd), .hd(hd), .mode_q(mode_q), .gain_q(gain_q),
        .clamp_q(clamp_q), .tint_q(tint_q), .line_sel_q(line_sel_q),
        .hold_q(hold_q), .sync_pol_q(sync_pol_q), .field_q(field_q)
    );

    task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [5:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic load_pulse();
        @(negedge clk); sload = 1'b1;
        @(negedge clk); sload = 1'b0;
    endtask

    task automatic vd_pulse();
        @(negedge clk); vd = pol;
        @(negedge clk); vd = ~pol;
    endtask

    task automatic hd_pulse();
        @(negedge clk); hd = pol;
        @(negedge clk); hd = ~pol;
    endtask

    task automatic t_reset();
        chk("R1 mode", 16'(mode_q), 16'h00);
        chk("R1 gain", 16'(gain_q), 16'h096);
        chk("R1 clamp", 16'(clamp_q), 16'h80);
        chk("R1 tint", 16'(tint_q), 16'h00);
        chk("R1 line", 16'(line_sel_q), 16'h000);
        chk("R1 hold", 16'(hold_q), 16'h0);
        chk("R1 pol", 16'(sync_pol_q), 16'h0);
        chk("R1 field", 16'(field_q), 16'h1);
    endtask

    task automatic t_pair_load();
        wr(6'h00, 6'h15);
        wr(6'h01, 6'h02);
        chk("R5 mode before load", 16'(mode_q), 16'h00);
        vd_pulse(); hd_pulse();
        chk("R5 mode ignores sync", 16'(mode_q), 16'h00);
        load_pulse();
        chk("R2 mode pair", 16'(mode_q), 16'h95);
    endtask

    task automatic t_pair_sync();
        wr(6'h02, 6'h3F);
        wr(6'h03, 6'h0A);
        load_pulse();
        chk("R6 gain ignores load", 16'(gain_q), 16'h096);
        vd_pulse();
        chk("R6 gain ignores vd", 16'(gain_q), 16'h096);
        hd_pulse();
        chk("R2 gain pair on line 0", 16'(gain_q), 16'h2BF);
    endtask

    task automatic t_line_select();
        wr(6'h10, 6'h03);
        wr(6'h11, 6'h00);
        load_pulse();
        chk("R11 line loaded", 16'(line_sel_q), 16'h003);
        wr(6'h08, 6'h2A);
        vd_pulse();
        for (int i = 0; i < 3; i++) hd_pulse();
        chk("R7 tint before line 3", 16'(tint_q), 16'h00);
        hd_pulse();
        chk("R7 tint on line 3", 16'(tint_q), 16'h2A);
        chk("R11 tint single slot", 16'(tint_q), 16'h2A);
    endtask

    task automatic t_lone_low();
        wr(6'h02, 6'h01);
        load_pulse();
        vd_pulse();
        for (int i = 0; i < 4; i++) hd_pulse();
        chk("R3 gain after lone low", 16'(gain_q), 16'h2BF);
    endtask

    task automatic t_lone_high();
        wr(6'h03, 6'h05);
        wr(6'h05, 6'h01);
        vd_pulse();
        for (int i = 0; i < 3; i++) hd_pulse();
        chk("R4 gain not early", 16'(gain_q), 16'h2BF);
        hd_pulse();
        chk("R4 gain lone high uses latch", 16'(gain_q), 16'h141);
        chk("R4 clamp lone high uses reset low", 16'(clamp_q), 16'h40);
    endtask

    task automatic t_hold();
        wr(6'h12, 6'h01);
        load_pulse();
        chk("R11 hold loaded", 16'(hold_q), 16'h1);
        wr(6'h14, 6'h00);
        vd_pulse();
        for (int i = 0; i < 4; i++) hd_pulse();
        chk("R8 field frozen by hold", 16'(field_q), 16'h1);
        wr(6'h12, 6'h00);
        load_pulse();
        chk("R8 hold released", 16'(hold_q), 16'h0);
        vd_pulse();
        for (int i = 0; i < 4; i++) hd_pulse();
        chk("R8 field after release", 16'(field_q), 16'h0);
    endtask

    task automatic t_unmapped();
        wr(6'h3F, 6'h3F);
        wr(6'h09, 6'h3F);
        wr(6'h06, 6'h3F);
        load_pulse();
        vd_pulse();
        for (int i = 0; i < 4; i++) hd_pulse();
        chk("R10 mode", 16'(mode_q), 16'h95);
        chk("R10 gain", 16'(gain_q), 16'h141);
        chk("R10 clamp", 16'(clamp_q), 16'h40);
        chk("R10 tint", 16'(tint_q), 16'h2A);
        chk("R10 line", 16'(line_sel_q), 16'h003);
        chk("R10 field", 16'(field_q), 16'h0);
    endtask

    task automatic t_polarity();
        wr(6'h13, 6'h01);
        @(negedge clk); sload = 1'b1;
        @(negedge clk); sload = 1'b0; pol = 1'b1; vd = 1'b0; hd = 1'b0;
        chk("R9 polarity loaded", 16'(sync_pol_q), 16'h1);
        wr(6'h08, 6'h11);
        vd_pulse();
        for (int i = 0; i < 3; i++) hd_pulse();
        chk("R9 tint before line 3 active high", 16'(tint_q), 16'h2A);
        hd_pulse();
        chk("R9 tint on line 3 active high", 16'(tint_q), 16'h11);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pair_load();
        t_pair_sync();
        t_line_select();
        t_lone_low();
        t_lone_high();
        t_hold();
        t_unmapped();
        t_polarity();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule